// File: doc/BRIEF.md
# Complex Baseband Frequency Tuner

This block moves a complex sample stream down in frequency by a programmable offset. It sits between two decimating filters on a 60 Msps complex path. A 32-bit phase accumulator forms the oscillator. A quarter-wave sine table, folded by quadrant, gives the cosine and sine of the current phase. Four multipliers then rotate each incoming I/Q pair by the negative of that phase. As a result, a tone at a positive offset equal to the oscillator frequency comes out at 0 Hz.

After reset the tuning word is set so that a signal centred at +8 MHz lands at DC. Software can write a new word at any time, with no reset and no restart of the phase. This retunes the block to pull a different 5 MHz slice of the 29–47 MHz front-end band down to baseband. A negative offset is obtained by writing the two's complement of the word.

Top module: `nco_tuner`

## Requirements
- R1: While reset is held, and on the first cycle after it, `out_valid_o` is 0 and both output samples are 0. Reset also clears the phase to 0 and loads the tuning word 572662306, which is round(8/60 · 2^32).
- R2: Every sample accepted with `in_valid_i` = 1 produces exactly one output with `out_valid_o` = 1, exactly 4 clock cycles later. Output order follows input order. There is no other output valid.
- R3: For a sample taken at phase P, let k be the top 10 bits of P and θ = (k + 0.5) · 2π / 1024. Then `out_re_o` = I·cosθ + Q·sinθ and `out_im_o` = Q·cosθ − I·sinθ, rounded to nearest, within 1 LSB. With the reset word, a +8 MHz tone at 60 Msps comes out as a DC value.
- R4: The phase advances by the tuning word only on a cycle with `in_valid_i` = 1. A gap of idle cycles leaves the phase unchanged, so the rotation seen by the next sample does not depend on the gap.
- R5: A word written with `fcw_we_i` = 1 is the step used by the first valid sample in the same cycle or later. The accumulated phase is kept across the write.
- R6: A rotated result above 2047 is output as 2047, and one below −2048 is output as −2048 (12-bit two's complement output).
- R7: When `out_valid_o` = 0, `out_re_o` and `out_im_o` keep the values of the last valid output.
- R8: A tuning word equal to 2^32 minus the reset word shifts a −8 MHz tone to DC. This shows that any offset, positive or negative, is selected by the word alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fcw_we_i | input | 1 | Load strobe for the tuning word |
| fcw_i | input | 32 | New tuning word (phase step per valid sample) |
| in_valid_i | input | 1 | Input sample qualifier |
| in_re_i | input | 12 | Input I, signed |
| in_im_i | input | 12 | Input Q, signed |
| out_valid_o | output | 1 | Output sample qualifier |
| out_re_o | output | 12 | Rotated I, signed, saturated |
| out_im_o | output | 12 | Rotated Q, signed, saturated |

## Verification
A sample driven with `in_valid_i` = 1 is due at the outputs on the fourth clock edge after it is captured. The bench therefore compares each output against a queue entry pushed four cycles earlier. It samples at the falling edge, well clear of the edge that updates the outputs. The expected value uses the bench's own phase model, which applies a write in the cycle it is made and advances only on valid samples. The latency test counts falling edges to confirm the single valid pulse appears on exactly the fourth. The hold and saturation checks read the outputs only after the pipeline has drained through idle cycles.

// File: rtl/nco_tuner_pkg.sv
package nco_tuner_pkg;

  // pi scaled by 2^30
  localparam longint PI_Q30 = 64'sd3373259426;

  // Quarter-wave sine entry idx of 2^aw, sampled at the bin centre, scaled to 2^(amp_w-1)-1
  function automatic int quarter_sine(input int idx, input int aw, input int amp_w);
    longint x, x2, term, acc;
    x    = (PI_Q30 * longint'(2 * idx + 1)) >>> (aw + 2);
    x2   = (x * x) >>> 30;
    term = x;
    acc  = x;
    for (int n = 1; n <= 6; n++) begin
      term = -((term * x2) >>> 30) / longint'((2 * n) * (2 * n + 1));
      acc  = acc + term;
    end
    return int'((acc * ((longint'(1) <<< (amp_w - 1)) - 1) + (longint'(1) <<< 29)) >>> 30);
  endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int          PHASE_W   = 32,
  parameter int unsigned FCW_RESET = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               adv_i,
  input  logic               fcw_we_i,
  input  logic [PHASE_W-1:0] fcw_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic [PHASE_W-1:0] fcw_o
);
  logic [PHASE_W-1:0] fcw_q, phase_q, step;

  // a write in the same cycle already steers this advance
  assign step = fcw_we_i ? fcw_i : fcw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fcw_q   <= PHASE_W'(FCW_RESET);
      phase_q <= '0;
    end else begin
      if (fcw_we_i) fcw_q <= fcw_i;
      if (adv_i)    phase_q <= phase_q + step;
    end
  end

  assign phase_o = phase_q;
  assign fcw_o   = fcw_q;
endmodule

// File: rtl/nco_sincos.sv
module nco_sincos #(
  parameter int LUT_AW = 8,
  parameter int AMP_W  = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [LUT_AW+1:0]       phase_i,
  output logic signed [AMP_W-1:0] cos_o,
  output logic signed [AMP_W-1:0] sin_o
);
  localparam int LUT_N = 1 << LUT_AW;

  logic signed [AMP_W-1:0] rom [LUT_N];

  for (genvar k = 0; k < LUT_N; k++) begin : g_rom
    localparam int ENTRY = nco_tuner_pkg::quarter_sine(k, LUT_AW, AMP_W);
    assign rom[k] = AMP_W'(ENTRY);
  end

  logic [1:0]              quad, quad_q;
  logic [LUT_AW-1:0]       addr;
  logic signed [AMP_W-1:0] s_raw_q, c_raw_q, cos_d, sin_d;

  assign {quad, addr} = phase_i;

  // stage 1: two reads, cos via mirrored address
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quad_q  <= '0;
      s_raw_q <= '0;
      c_raw_q <= '0;
    end else begin
      quad_q  <= quad;
      s_raw_q <= rom[addr];
      c_raw_q <= rom[~addr];
    end
  end

  // stage 2: quadrant fold
  always_comb begin
    unique case (quad_q)
      2'd0: begin cos_d =  c_raw_q; sin_d =  s_raw_q; end
      2'd1: begin cos_d = -s_raw_q; sin_d =  c_raw_q; end
      2'd2: begin cos_d = -c_raw_q; sin_d = -s_raw_q; end
      default: begin cos_d = s_raw_q; sin_d = -c_raw_q; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cos_o <= '0;
      sin_o <= '0;
    end else begin
      cos_o <= cos_d;
      sin_o <= sin_d;
    end
  end
endmodule

// File: rtl/nco_cmplx_rot.sv
module nco_cmplx_rot #(
  parameter int DATA_W = 12,
  parameter int AMP_W  = 16,
  parameter int OUT_W  = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] re_i,
  input  logic signed [DATA_W-1:0] im_i,
  input  logic signed [AMP_W-1:0]  cos_i,
  input  logic signed [AMP_W-1:0]  sin_i,
  output logic                     valid_o,
  output logic signed [OUT_W-1:0]  re_o,
  output logic signed [OUT_W-1:0]  im_o
);
  localparam int PROD_W = DATA_W + AMP_W;
  localparam int SUM_W  = PROD_W + 1;
  localparam int SHIFT  = AMP_W - 1;
  localparam int RES_W  = SUM_W - SHIFT;
  localparam logic signed [SUM_W-1:0] BIAS =
    {{(SUM_W-SHIFT){1'b0}}, 1'b1, {(SHIFT-1){1'b0}}};
  localparam logic signed [RES_W-1:0] HI = {{(RES_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [RES_W-1:0] LO = {{(RES_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  function automatic logic signed [OUT_W-1:0] clip(input logic signed [RES_W-1:0] v);
    if (v > HI)      return {1'b0, {(OUT_W-1){1'b1}}};
    else if (v < LO) return {1'b1, {(OUT_W-1){1'b0}}};
    else             return v[OUT_W-1:0];
  endfunction

  logic signed [PROD_W-1:0] p_rc, p_is, p_ic, p_rs;
  logic                     vld_a;
  logic signed [SUM_W-1:0]  sum_re, sum_im, bia_re, bia_im;

  // stage A: four products
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_rc <= '0; p_is <= '0; p_ic <= '0; p_rs <= '0;
      vld_a <= 1'b0;
    end else begin
      p_rc  <= re_i * cos_i;
      p_is  <= im_i * sin_i;
      p_ic  <= im_i * cos_i;
      p_rs  <= re_i * sin_i;
      vld_a <= valid_i;
    end
  end

  // conjugate rotation, round half up
  assign sum_re = {p_rc[PROD_W-1], p_rc} + {p_is[PROD_W-1], p_is};
  assign sum_im = {p_ic[PROD_W-1], p_ic} - {p_rs[PROD_W-1], p_rs};
  assign bia_re = sum_re + BIAS;
  assign bia_im = sum_im + BIAS;

  // stage B: outputs load only on valid
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      re_o    <= '0;
      im_o    <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= vld_a;
      if (vld_a) begin
        re_o <= clip(bia_re[SUM_W-1:SHIFT]);
        im_o <= clip(bia_im[SUM_W-1:SHIFT]);
      end
    end
  end
endmodule

// File: rtl/nco_tuner.sv
module nco_tuner #(
  parameter int          DATA_W    = 12,
  parameter int          OUT_W     = 12,
  parameter int          PHASE_W   = 32,
  parameter int          LUT_AW    = 8,
  parameter int          AMP_W     = 16,
  parameter int unsigned FCW_RESET = 32'd572662306
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     fcw_we_i,
  input  logic [PHASE_W-1:0]       fcw_i,
  input  logic                     in_valid_i,
  input  logic signed [DATA_W-1:0] in_re_i,
  input  logic signed [DATA_W-1:0] in_im_i,
  output logic                     out_valid_o,
  output logic signed [OUT_W-1:0]  out_re_o,
  output logic signed [OUT_W-1:0]  out_im_o
);
  localparam int LUT_PW = LUT_AW + 2;
  localparam int ALIGN  = 2;  // sincos pipeline depth

  logic [PHASE_W-1:0]      phase_q, fcw_q;
  logic signed [AMP_W-1:0] cos_w, sin_w;
  logic [ALIGN-1:0]        vld_sr;
  logic signed [DATA_W-1:0] re_d [ALIGN];
  logic signed [DATA_W-1:0] im_d [ALIGN];

  nco_phase_acc #(
    .PHASE_W  (PHASE_W),
    .FCW_RESET(FCW_RESET)
  ) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (in_valid_i),
    .fcw_we_i(fcw_we_i),
    .fcw_i   (fcw_i),
    .phase_o (phase_q),
    .fcw_o   (fcw_q)
  );

  nco_sincos #(
    .LUT_AW(LUT_AW),
    .AMP_W (AMP_W)
  ) u_lut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phase_i(phase_q[PHASE_W-1 -: LUT_PW]),
    .cos_o  (cos_w),
    .sin_o  (sin_w)
  );

  // align samples with table output
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_sr <= '0;
      for (int i = 0; i < ALIGN; i++) begin
        re_d[i] <= '0;
        im_d[i] <= '0;
      end
    end else begin
      vld_sr  <= {vld_sr[ALIGN-2:0], in_valid_i};
      re_d[0] <= in_re_i;
      im_d[0] <= in_im_i;
      for (int i = 1; i < ALIGN; i++) begin
        re_d[i] <= re_d[i-1];
        im_d[i] <= im_d[i-1];
      end
    end
  end

  nco_cmplx_rot #(
    .DATA_W(DATA_W),
    .AMP_W (AMP_W),
    .OUT_W (OUT_W)
  ) u_rot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(vld_sr[ALIGN-1]),
    .re_i   (re_d[ALIGN-1]),
    .im_i   (im_d[ALIGN-1]),
    .cos_i  (cos_w),
    .sin_i  (sin_w),
    .valid_o(out_valid_o),
    .re_o   (out_re_o),
    .im_o   (out_im_o)
  );
endmodule

// File: rtl/nco_tuner_chk.sv
module nco_tuner_chk #(
  parameter int PHASE_W = 32,
  parameter int OUT_W   = 12
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    in_valid_i,
  input logic                    fcw_we_i,
  input logic [PHASE_W-1:0]      fcw_i,
  input logic [PHASE_W-1:0]      phase_q,
  input logic [PHASE_W-1:0]      fcw_q,
  input logic                    out_valid_o,
  input logic signed [OUT_W-1:0] out_re_o,
  input logic signed [OUT_W-1:0] out_im_o
);
  logic [2:0] since_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              since_rst <= '0;
    else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    since_rst == 3'd4 |-> out_valid_o == $past(in_valid_i, 4)); // R2

  AST_PHASE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> phase_q == $past(phase_q)); // R4

  AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> phase_q == $past(phase_q) + $past(fcw_we_i ? fcw_i : fcw_q)); // R5

  AST_FCW_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fcw_we_i |=> fcw_q == $past(fcw_i)); // R5

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> $stable(out_re_o) && $stable(out_im_o)); // R7
endmodule

bind nco_tuner nco_tuner_chk #(
  .PHASE_W(PHASE_W),
  .OUT_W  (OUT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .fcw_we_i   (fcw_we_i),
  .fcw_i      (fcw_i),
  .phase_q    (phase_q),
  .fcw_q      (fcw_q),
  .out_valid_o(out_valid_o),
  .out_re_o   (out_re_o),
  .out_im_o   (out_im_o)
);

// File: tb/nco_tuner_bench.sv
module nco_tuner_bench;
  localparam int  CLK_P   = 10;
  localparam real PI      = 3.14159265358979;
  localparam logic [31:0] W_DEF = 32'd572662306;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               fcw_we = 1'b0;
  logic [31:0]        fcw = '0;
  logic               in_valid = 1'b0;
  logic signed [11:0] in_re = '0, in_im = '0;
  logic               out_valid;
  logic signed [11:0] out_re, out_im;

  int n_run = 0, n_fail = 0;
  logic [31:0] b_acc, b_word;
  int    q_re[$], q_im[$];
  string q_tag[$];

  always #(CLK_P/2) clk = ~clk;

  nco_tuner u_nco_tuner (
    .clk_i(clk), .rst_ni(rst_n), .fcw_we_i(fcw_we), .fcw_i(fcw),
    .in_valid_i(in_valid), .in_re_i(in_re), .in_im_i(in_im),
    .out_valid_o(out_valid), .out_re_o(out_re), .out_im_o(out_im));

  function automatic int clampr(input real x);
    if (x > 2047.0)  return 2047;
    if (x < -2048.0) return -2048;
    return int'(x);
  endfunction

  function automatic int iabs(input int v);
    return v < 0 ? -v : v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act_a, input int exp_a, input int act_b, input int exp_b);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual (%0d,%0d) expected (%0d,%0d)", req, what, act_a, act_b, exp_a, exp_b);
    end
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  // every valid output is compared with the entry pushed 4 cycles before
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_re.size() == 0) begin
        check(1'b0, "R2", "unexpected valid", int'(out_re), 0, int'(out_im), 0);
      end else begin
        int er, ei;
        string tg;
        er = q_re.pop_front();
        ei = q_im.pop_front();
        tg = q_tag.pop_front();
        check(iabs(int'(out_re) - er) <= 1 && iabs(int'(out_im) - ei) <= 1, tg, "rotated sample",
              int'(out_re), er, int'(out_im), ei);
      end
    end
  end

  task automatic step(input bit v, input int re, input int im, input bit we,
                      input logic [31:0] w, input string tag);
    @(negedge clk);
    in_valid = v; in_re = 12'(re); in_im = 12'(im);
    fcw_we = we; fcw = w;
    if (v) begin
      real ph;
      ph = (real'(b_acc[31:22]) + 0.5) * 2.0 * PI / 1024.0;
      q_re.push_back(clampr(re * $cos(ph) + im * $sin(ph)));
      q_im.push_back(clampr(im * $cos(ph) - re * $sin(ph)));
      q_tag.push_back(tag);
    end
    if (we) b_word = w;
    if (v)  b_acc  = b_acc + b_word;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0, 1'b0, '0, "");
  endtask

  task automatic reset_dut;
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; fcw_we = 1'b0; in_re = '0; in_im = '0;
    q_re.delete(); q_im.delete(); q_tag.delete();
    b_acc = '0; b_word = W_DEF;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset;  // R1
    reset_dut();
    @(negedge clk);
    check(out_valid == 1'b0 && out_re == 0 && out_im == 0, "R1", "reset state",
          int'(out_re), 0, int'(out_im), 0);
  endtask

  task automatic t_latency;  // R2
    reset_dut();
    step(1'b1, 500, -300, 1'b0, '0, "R2");
    for (int c = 1; c <= 5; c++) begin
      step(1'b0, 0, 0, 1'b0, '0, "");
      check(out_valid == (c == 4), "R2", $sformatf("valid at cycle %0d", c),
            int'(out_valid), int'(c == 4), 0, 0);
    end
  endtask

  task automatic t_tone_dc;  // R3: +8 MHz to DC with reset word
    reset_dut();
    for (int n = 0; n < 60; n++)
      step(1'b1, int'(1500.0 * $cos(2.0 * PI * 8.0 / 60.0 * n)),
                 int'(1500.0 * $sin(2.0 * PI * 8.0 / 60.0 * n)), 1'b0, '0, "R3");
    idle(6);
    check(iabs(int'(out_re) - 1500) <= 3 && iabs(int'(out_im)) <= 8, "R3", "tone at DC",
          int'(out_re), 1500, int'(out_im), 0);
  endtask

  task automatic t_gaps;  // R4
    reset_dut();
    for (int n = 0; n < 30; n++) begin
      step(1'b1, int'(1800.0 * $cos(2.0 * PI * 8.0 / 60.0 * n)),
                 int'(1800.0 * $sin(2.0 * PI * 8.0 / 60.0 * n)), 1'b0, '0, "R4");
      idle(n % 3);
    end
    idle(6);
    check(iabs(int'(out_re) - 1800) <= 3 && iabs(int'(out_im)) <= 9, "R4", "gaps keep phase",
          int'(out_re), 1800, int'(out_im), 0);
  endtask

  task automatic t_retune;  // R5
    reset_dut();
    for (int n = 0; n < 3; n++) step(1'b1, 1000, 200, 1'b0, '0, "R5");
    step(1'b0, 0, 0, 1'b1, 32'h4000_0000, "");
    for (int n = 0; n < 5; n++) step(1'b1, 1000, 200, 1'b0, '0, "R5");
    step(1'b1, -700, 900, 1'b1, 32'hC000_0000, "R5");
    for (int n = 0; n < 5; n++) step(1'b1, -700, 900, 1'b0, '0, "R5");
    idle(6);
  endtask

  task automatic t_saturate;  // R6, R7
    reset_dut();
    step(1'b1, 2047, 2047, 1'b0, '0, "R6");
    idle(6);
    check(out_re == 12'sd2047, "R6", "positive clip", int'(out_re), 2047, int'(out_im), int'(out_im));
    check(out_valid == 1'b0, "R7", "idle after drain", int'(out_valid), 0, 0, 0);
    step(1'b1, -2048, -2048, 1'b0, '0, "R6");
    idle(6);
    check(out_re == -12'sd2048, "R6", "negative clip", int'(out_re), -2048, int'(out_im), int'(out_im));
    begin
      logic signed [11:0] hr, hi;
      hr = out_re; hi = out_im;
      idle(3);
      check(out_re == hr && out_im == hi, "R7", "hold between valids",
            int'(out_re), int'(hr), int'(out_im), int'(hi));
    end
  endtask

  task automatic t_negative;  // R8
    reset_dut();
    step(1'b0, 0, 0, 1'b1, 32'd0 - W_DEF, "");
    for (int n = 0; n < 45; n++)
      step(1'b1, int'(1200.0 * $cos(2.0 * PI * 8.0 / 60.0 * n)),
                 -int'(1200.0 * $sin(2.0 * PI * 8.0 / 60.0 * n)), 1'b0, '0, "R8");
    idle(6);
    check(iabs(int'(out_re) - 1200) <= 3 && iabs(int'(out_im)) <= 7, "R8", "negative tone at DC",
          int'(out_re), 1200, int'(out_im), 0);
  endtask

  initial begin
    #(CLK_P * 20000);
    n_fail++;
    $display("FAIL R2 watchdog expired");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_tone_dc();
    t_gaps();
    t_retune();
    t_saturate();
    t_negative();
    check(q_re.size() == 0, "R2", "all samples delivered", q_re.size(), 0, 0, 0);
    summary();
    $finish;
  end
endmodule